// File: doc/BRIEF.md
# Graphics Unit CPU Register Interface

This block sits between the processor bus and the picture generator. It watches every bus cycle, picks out accesses that fall in the graphics register window, and turns them into register updates, read data, and one-cycle access strobes toward video memory and sprite memory. The eight register slots repeat every eight bytes across the whole window, so only the low three address bits pick a slot.

It keeps the control and mask bytes, three sticky event flags (vertical blank, sprite-zero collision, sprite overflow), a scroll pair and a video-memory pointer. The scroll pair and the pointer are each loaded by two writes in a row, and one shared phase bit decides which half a write lands in. Data-port accesses move the video-memory pointer forward by one or by a row, and sprite data writes move the sprite pointer forward by one. A write to a separate I/O address raises a one-cycle start request for a 256-byte sprite copy. An interrupt request is raised while vertical blank is flagged and the control byte enables it.

The storage arrays, the renderer and the copy engine are outside this block. The block only gives them addresses, data and strobes.

Top module: `gfx_cpu_regs`

## Requirements
- R1: An access hits the window when 0x2000 <= cpu_addr <= 0x3FFF. The slot is cpu_addr[2:0]: 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 video pointer, 7 video data. Accesses outside the window change no register and give read data 0. At most one of vram_wr, vram_rd and spr_wr is high in a cycle.
- R2: A write to slot 0 or slot 1 shows on ctrl_q or mask_q from the next cycle on. Control bit 7 enables the interrupt and control bit 2 picks the pointer step.
- R3: A read of slot 2 returns {vblank, sprite-zero hit, overflow, 5'b0} (bits 7, 6, 5) in the same cycle. A read of slot 4 returns spr_rdata, a read of slot 7 returns vram_rdata, and a read of any other slot returns 0.
- R4: A status read clears the vertical-blank flag and returns the shared phase bit to "first" for the next cycle. If vblank_start arrives in the same cycle, the flag ends set.
- R5: vblank_start sets the vertical-blank flag. spr0_hit_set and spr_ovf_set set their sticky flags. vblank_end clears all three flags, but a set strobe in the same cycle wins.
- R6: nmi is high exactly when the vertical-blank flag is set and control bit 7 is 1.
- R7: A write to slot 5 loads scroll_x when the phase is first and scroll_y when it is second, and flips the phase.
- R8: A write to slot 6 loads vram_addr[13:8] from cpu_wdata[5:0] when the phase is first and vram_addr[7:0] when it is second, and flips the same phase bit as R7.
- R9: A write to slot 7 pulses vram_wr with vram_wdata = cpu_wdata, and a read pulses vram_rd, both at the current vram_addr. Afterwards vram_addr advances by 1, or by 32 when control bit 2 is 1, wrapping modulo 2^14.
- R10: A write to slot 3 loads spr_addr. A write to slot 4 pulses spr_wr at the current spr_addr and then advances spr_addr by one modulo 256. A read of slot 4 does not move spr_addr.
- R11: A write to 0x4014 raises dma_start for exactly the next cycle, with dma_page holding the written byte.
- R12: After a synchronous reset every register, flag and pointer is 0, the phase is first, and nmi and dma_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Bus address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the read cycle |
| vblank_start | input | 1 | Vertical blank begins |
| vblank_end | input | 1 | Vertical blank ends, flags clear |
| spr0_hit_set | input | 1 | Sprite-zero collision event |
| spr_ovf_set | input | 1 | Sprite overflow event |
| vram_rdata | input | 8 | Video memory data at vram_addr |
| spr_rdata | input | 8 | Sprite memory data at spr_addr |
| ctrl_q | output | 8 | Control byte |
| mask_q | output | 8 | Mask byte |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Video memory pointer |
| vram_wr | output | 1 | Video memory write strobe |
| vram_rd | output | 1 | Video memory read strobe |
| vram_wdata | output | 8 | Video memory write data |
| spr_addr | output | 8 | Sprite memory pointer |
| spr_wr | output | 1 | Sprite memory write strobe |
| spr_wdata | output | 8 | Sprite memory write data |
| dma_start | output | 1 | Sprite copy start pulse |
| dma_page | output | 8 | Source page for the copy |
| nmi | output | 1 | Interrupt request |

## Verification
The bench goes after the shared phase bit. It splits a scroll write and a pointer write across one toggle and resets the toggle with a status read between two halves. A design with separate toggles, or one that does not reset the toggle on a status read, would load the wrong half. It steers the video pointer to 0x3FFF and the sprite pointer to 0xFF and checks that both wrap, so a design that carries into a fifteenth bit or saturates is caught. It also issues a status read in the same cycle as vblank_start, and a design that lets the read's clear win would drop that blank and its interrupt. Mirrored addresses, addresses just outside the window and the copy-trigger address come up in a long seeded random mix, so a decoder that looks at too few or too many address bits disagrees with the bench model.

// File: rtl/gfx_regs_pkg.sv
package gfx_regs_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_STAT = 3'd2,
        REG_SPRA = 3'd3,
        REG_SPRD = 3'd4,
        REG_SCRL = 3'd5,
        REG_VADR = 3'd6,
        REG_VDAT = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    typedef struct packed {
        logic vblank;
        logic spr0_hit;
        logic spr_ovf;
    } stat_flags_t;

    localparam int CTRL_NMI_BIT = 7;
    localparam int CTRL_INC_BIT = 2;

    function automatic logic [7:0] stat_byte(stat_flags_t f);
        return {f.vblank, f.spr0_hit, f.spr_ovf, 5'b0};
    endfunction

    function automatic logic hits(bus_req_t r, logic is_wr, reg_sel_e s);
        return (is_wr ? r.wr : r.rd) && (r.sel == s);
    endfunction

endpackage

// File: rtl/gfx_bus_decode.sv
module gfx_bus_decode
    import gfx_regs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'h2000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 16'h3FFF,
    parameter logic [ADDR_W-1:0] DMA_ADDR = 16'h4014
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_req_t          req,
    output logic              dma_wr
);
    localparam int SEL_W = 3;

    logic in_win;

    always_comb begin
        in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
        req.wr  = wr && in_win;
        req.rd  = rd && !wr && in_win;
        req.sel = reg_sel_e'(addr[SEL_W-1:0]);
        dma_wr  = wr && (addr == DMA_ADDR);
    end
endmodule

// File: rtl/gfx_status_unit.sv
module gfx_status_unit
    import gfx_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stat_rd,
    input  logic        vbl_start,
    input  logic        vbl_end,
    input  logic        hit_set,
    input  logic        ovf_set,
    input  logic        nmi_en,
    output stat_flags_t flags,
    output logic        nmi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (vbl_start)                flags.vblank <= 1'b1;
            else if (vbl_end || stat_rd)  flags.vblank <= 1'b0;
            if (hit_set)                  flags.spr0_hit <= 1'b1;
            else if (vbl_end)             flags.spr0_hit <= 1'b0;
            if (ovf_set)                  flags.spr_ovf <= 1'b1;
            else if (vbl_end)             flags.spr_ovf <= 1'b0;
        end
    end

    assign nmi = flags.vblank && nmi_en;

    p_vbl_set_r5: assert property (@(posedge clk) disable iff (rst)
        vbl_start |=> flags.vblank);
    p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !vbl_start) |=> !flags.vblank);
    p_end_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (vbl_end && !hit_set && !ovf_set) |=> (!flags.spr0_hit && !flags.spr_ovf));
    p_nmi_off_r6: assert property (@(posedge clk) disable iff (rst)
        (vbl_end && !vbl_start) |=> !nmi);
endmodule

// File: rtl/gfx_addr_unit.sv
module gfx_addr_unit
    import gfx_regs_pkg::*;
#(
    parameter int VADDR_W = 14,
    parameter int STRIDE  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [7:0]         wdata,
    input  logic               inc_row,
    output logic [7:0]         scroll_x,
    output logic [7:0]         scroll_y,
    output logic [VADDR_W-1:0] vram_addr,
    output logic [7:0]         spr_addr
);
    localparam int HI_W = VADDR_W - 8;

    logic               second;
    logic [VADDR_W-1:0] step;
    logic               pair_wr;
    logic               data_acc;

    always_comb begin
        step     = inc_row ? VADDR_W'(STRIDE) : VADDR_W'(1);
        pair_wr  = hits(req, 1'b1, REG_SCRL) || hits(req, 1'b1, REG_VADR);
        data_acc = hits(req, 1'b1, REG_VDAT) || hits(req, 1'b0, REG_VDAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second    <= 1'b0;
            scroll_x  <= '0;
            scroll_y  <= '0;
            vram_addr <= '0;
            spr_addr  <= '0;
        end else begin
            if (hits(req, 1'b0, REG_STAT)) second <= 1'b0;
            else if (pair_wr)              second <= !second;

            if (hits(req, 1'b1, REG_SCRL)) begin
                if (second) scroll_y <= wdata;
                else        scroll_x <= wdata;
            end

            if (hits(req, 1'b1, REG_VADR)) begin
                if (second) vram_addr <= {vram_addr[VADDR_W-1:8], wdata};
                else        vram_addr <= {wdata[HI_W-1:0], vram_addr[7:0]};
            end else if (data_acc) begin
                vram_addr <= vram_addr + step;
            end

            if (hits(req, 1'b1, REG_SPRA))      spr_addr <= wdata;
            else if (hits(req, 1'b1, REG_SPRD)) spr_addr <= spr_addr + 8'd1;
        end
    end

    p_toggle_home_r4: assert property (@(posedge clk) disable iff (rst)
        hits(req, 1'b0, REG_STAT) |=> !second);
    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (rst)
        pair_wr |=> (second != $past(second)));
    p_vram_step_r9: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> (vram_addr == $past(vram_addr) + $past(step)));
    p_spr_step_r10: assert property (@(posedge clk) disable iff (rst)
        hits(req, 1'b1, REG_SPRD) |=> (spr_addr == $past(spr_addr) + 8'd1));
endmodule

// File: rtl/gfx_cpu_regs.sv
module gfx_cpu_regs
    import gfx_regs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int VADDR_W = 14,
    parameter int STRIDE  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    input  logic               vblank_start,
    input  logic               vblank_end,
    input  logic               spr0_hit_set,
    input  logic               spr_ovf_set,
    input  logic [7:0]         vram_rdata,
    input  logic [7:0]         spr_rdata,
    output logic [7:0]         ctrl_q,
    output logic [7:0]         mask_q,
    output logic [7:0]         scroll_x,
    output logic [7:0]         scroll_y,
    output logic [VADDR_W-1:0] vram_addr,
    output logic               vram_wr,
    output logic               vram_rd,
    output logic [7:0]         vram_wdata,
    output logic [7:0]         spr_addr,
    output logic               spr_wr,
    output logic [7:0]         spr_wdata,
    output logic               dma_start,
    output logic [7:0]         dma_page,
    output logic               nmi
);
    bus_req_t    req;
    logic        dma_wr;
    stat_flags_t flags;

    gfx_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (cpu_addr),
        .wr   (cpu_wr),
        .rd   (cpu_rd),
        .req  (req),
        .dma_wr (dma_wr)
    );

    gfx_status_unit u_stat (
        .clk       (clk),
        .rst       (rst),
        .stat_rd   (hits(req, 1'b0, REG_STAT)),
        .vbl_start (vblank_start),
        .vbl_end   (vblank_end),
        .hit_set   (spr0_hit_set),
        .ovf_set   (spr_ovf_set),
        .nmi_en    (ctrl_q[CTRL_NMI_BIT]),
        .flags     (flags),
        .nmi       (nmi)
    );

    gfx_addr_unit #(.VADDR_W(VADDR_W), .STRIDE(STRIDE)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wdata     (cpu_wdata),
        .inc_row   (ctrl_q[CTRL_INC_BIT]),
        .scroll_x  (scroll_x),
        .scroll_y  (scroll_y),
        .vram_addr (vram_addr),
        .spr_addr  (spr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            mask_q    <= '0;
            dma_start <= 1'b0;
            dma_page  <= '0;
        end else begin
            if (hits(req, 1'b1, REG_CTRL)) ctrl_q <= cpu_wdata;
            if (hits(req, 1'b1, REG_MASK)) mask_q <= cpu_wdata;
            dma_start <= dma_wr;
            if (dma_wr) dma_page <= cpu_wdata;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                REG_STAT: cpu_rdata = stat_byte(flags);
                REG_SPRD: cpu_rdata = spr_rdata;
                REG_VDAT: cpu_rdata = vram_rdata;
                default:  cpu_rdata = '0;
            endcase
        end
        vram_wr    = hits(req, 1'b1, REG_VDAT);
        vram_rd    = hits(req, 1'b0, REG_VDAT);
        spr_wr     = hits(req, 1'b1, REG_SPRD);
        vram_wdata = cpu_wdata;
        spr_wdata  = cpu_wdata;
    end

    p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vram_wr, vram_rd, spr_wr}));
    p_outside_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr < ADDR_W'(16'h2000)) |=> ($stable(ctrl_q) && $stable(mask_q)));
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
        hits(req, 1'b1, REG_CTRL) |=> (ctrl_q == $past(cpu_wdata)));
    p_dma_page_r11: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> (dma_page == $past(cpu_wdata)));
endmodule

// File: tb/gfx_cpu_regs_test.sv
module gfx_cpu_regs_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_wr, cpu_rd;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        vblank_start, vblank_end, spr0_hit_set, spr_ovf_set;
    logic [7:0]  vram_rdata, spr_rdata;
    logic [7:0]  ctrl_q, mask_q, scroll_x, scroll_y, spr_addr, vram_wdata, spr_wdata, dma_page;
    logic [13:0] vram_addr;
    logic        vram_wr, vram_rd, spr_wr, dma_start, nmi;

    always #10 clk = ~clk;

    gfx_cpu_regs uut (.*);

    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the register state
    logic [7:0]  m_ctrl, m_mask, m_sx, m_sy, m_sa, m_page;
    logic [13:0] m_va;
    logic        m_vbl, m_hit, m_ovf, m_sec, m_dma;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return (a >= 16'h2000) && (a <= 16'h3FFF);
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_vbl, m_hit, m_ovf, 5'b0};
    endfunction

    task automatic check_state();
        chk("R2 ctrl", ctrl_q, m_ctrl);
        chk("R2 mask", mask_q, m_mask);
        chk("R7 scroll_x", scroll_x, m_sx);
        chk("R7 scroll_y", scroll_y, m_sy);
        chk("R8 vram_addr", vram_addr, m_va);
        chk("R10 spr_addr", spr_addr, m_sa);
        chk("R6 nmi", nmi, m_vbl & m_ctrl[7]);
        chk("R11 dma_start", dma_start, m_dma);
        chk("R11 dma_page", dma_page, m_page);
    endtask

    task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] d,
                          input logic vs, input logic ve, input logic hs, input logic os);
        logic [2:0] s;
        logic       w;
        logic [7:0] exp_rd;
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
        vblank_start = vs; vblank_end = ve; spr0_hit_set = hs; spr_ovf_set = os;
        vram_rdata = 8'($urandom); spr_rdata = 8'($urandom);
        #5;
        s = a[2:0];
        w = in_win(a);
        exp_rd = 8'h00;
        if (!wr && w) begin
            if (s == 3'd2)      exp_rd = exp_status();
            else if (s == 3'd4) exp_rd = spr_rdata;
            else if (s == 3'd7) exp_rd = vram_rdata;
        end
        chk("R3 rdata", cpu_rdata, exp_rd);
        chk("R9 vram_wr", vram_wr, wr && w && s == 3'd7);
        chk("R9 vram_rd", vram_rd, !wr && w && s == 3'd7);
        chk("R10 spr_wr", spr_wr, wr && w && s == 3'd4);
        chk("R1 one strobe", 32'(vram_wr) + 32'(vram_rd) + 32'(spr_wr) <= 1, 1);
        if (wr && w && s == 3'd7) chk("R9 vram_wdata", vram_wdata, d);
        if (wr && w && s == 3'd4) chk("R10 spr_wdata", spr_wdata, d);
        @(posedge clk);
        #1;
        cpu_wr = 0; cpu_rd = 0;
        vblank_start = 0; vblank_end = 0; spr0_hit_set = 0; spr_ovf_set = 0;
        // model update
        m_hit = hs ? 1'b1 : (ve ? 1'b0 : m_hit);
        m_ovf = os ? 1'b1 : (ve ? 1'b0 : m_ovf);
        m_vbl = vs ? 1'b1 : ((ve || (!wr && w && s == 3'd2)) ? 1'b0 : m_vbl);
        if (w && wr) begin
            case (s)
                3'd0: m_ctrl = d;
                3'd1: m_mask = d;
                3'd3: m_sa = d;
                3'd4: m_sa = m_sa + 8'd1;
                3'd5: begin if (m_sec) m_sy = d; else m_sx = d; m_sec = !m_sec; end
                3'd6: begin
                    if (m_sec) m_va[7:0] = d; else m_va[13:8] = d[5:0];
                    m_sec = !m_sec;
                end
                default: m_va = m_va + (m_ctrl[2] ? 14'd32 : 14'd1);
                3'd2: ;
            endcase
        end else if (w && !wr) begin
            if (s == 3'd2) m_sec = 1'b0;
            if (s == 3'd7) m_va = m_va + (m_ctrl[2] ? 14'd32 : 14'd1);
        end
        m_dma = wr && (a == 16'h4014);
        if (m_dma) m_page = d;
        check_state();
    endtask

    task automatic wr8(input logic [15:0] a, input logic [7:0] d);
        access(a, 1'b1, d, 0, 0, 0, 0);
    endtask

    task automatic rd8(input logic [15:0] a);
        access(a, 1'b0, 8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cpu_addr = 0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = 0;
        vblank_start = 0; vblank_end = 0; spr0_hit_set = 0; spr_ovf_set = 0;
        vram_rdata = 0; spr_rdata = 0;
        m_ctrl = 0; m_mask = 0; m_sx = 0; m_sy = 0; m_sa = 0; m_page = 0;
        m_va = 0; m_vbl = 0; m_hit = 0; m_ovf = 0; m_sec = 0; m_dma = 0;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check_state();
        chk("R12 rdata after reset", cpu_rdata, 0);
        rst = 0;

        // R7/R8 shared phase: X, then pointer low half lands on second phase
        wr8(16'h2005, 8'h11);
        wr8(16'h3FFE, 8'h22);          // mirror of slot 6, second phase -> low byte
        chk("R8 low byte on shared phase", vram_addr, 14'h0022);
        // R4 status read resets phase
        wr8(16'h2006, 8'hFF);          // first phase: high = 0x3F
        rd8(16'h2002);
        wr8(16'h2005, 8'h33);          // must land in X again
        chk("R4 phase reset by status read", scroll_x, 8'h33);
        wr8(16'h2005, 8'h44);
        // R9 wrap at top of video space
        wr8(16'h2006, 8'hFF);
        wr8(16'h2006, 8'hFE);
        chk("R8 pointer load", vram_addr, 14'h3FFE);
        wr8(16'h2007, 8'hA5);
        rd8(16'h2007);
        chk("R9 wrap to zero", vram_addr, 14'h0000);
        // R9 row stride
        wr8(16'h2000, 8'h04);
        rd8(16'h2007);
        chk("R9 stride 32", vram_addr, 14'h0020);
        // R10 sprite wrap and read without advance
        wr8(16'h2003, 8'hFF);
        wr8(16'h2004, 8'h5A);
        chk("R10 sprite wrap", spr_addr, 8'h00);
        rd8(16'h2004);
        chk("R10 read keeps pointer", spr_addr, 8'h00);
        // R5/R6 flags and interrupt
        wr8(16'h2000, 8'h80);
        access(16'h0000, 1'b0, 0, 1, 0, 1, 1);
        chk("R6 nmi raised", nmi, 1);
        rd8(16'h2002);
        chk("R4 vblank cleared", nmi, 0);
        // R4 same-cycle set wins over read clear
        access(16'h2002, 1'b0, 0, 1, 0, 0, 0);
        chk("R4 set wins", nmi, 1);
        access(16'h0000, 1'b0, 0, 0, 1, 0, 0);
        rd8(16'h2002);
        chk("R5 end cleared flags", cpu_rdata, 0);
        // R11 copy trigger and R1 outside window
        wr8(16'h4014, 8'h02);
        chk("R11 start pulse", dma_start, 1);
        wr8(16'h1FFF, 8'h77);
        wr8(16'h4000, 8'h99);
        chk("R1 outside write ignored", ctrl_q, 8'h80);

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [15:0] a;
            k = int'($urandom % 10);
            if (k < 7)       a = 16'h2000 | 16'($urandom & 32'h1FFF);
            else if (k == 7) a = ($urandom % 2) ? 16'($urandom & 32'h1FFF)
                                                : 16'h4000 + 16'($urandom % 256);
            else if (k == 8) a = 16'h4014;
            else             a = 16'h0000;
            access(a, 1'($urandom % 2), 8'($urandom),
                   ($urandom % 8) == 0, ($urandom % 8) == 0,
                   ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule